// File: doc/BRIEF.md
# Pin Boundary-Scan Register Ring

This block is the boundary-scan data register for a small device with thirteen pins. The pins are eight data outputs, a clock input, a chip-enable input, a bidirectional reset/output-enable pin, a cascade-enable output and a configuration-trigger output. A separate test-access-port controller supplies the capture, shift and update strobes and a set of decoded instruction flags. The ring captures the pin state into a 25-stage shift register and shifts it between `tdi` and `tdo`. On the update strobe it copies the shifted pattern into a bank of update latches.

Each output pin owns two cells, one for the value and one for the drive enable. Each input owns one cell. When the instruction is external test or clamp, or during in-system programming, the pads take their value and enable from the update latches instead of the core. The high-impedance instruction, and in-system programming with the float flag set, switch every pad driver off at once. While clamp is active, a one-bit bypass stage carries the scan path and the pads keep their latched levels.

Top module: `bscan_pin_ring`

## Requirements
- R1: The ring has 25 stages. It is selected when `ir_extest` or `ir_sample` is high. While it is selected, each clock with `shift_dr` high moves `tdi` into stage 24 and every stage down by one. `tdo` shows stage 0.
- R2: While the ring is selected, a clock with `capture_dr` high loads every stage. A value stage loads `core_val[k]`, an enable stage loads `core_oe[k]` and an input stage loads `pin_in[j]`. The output index k runs 0..7 for data bits 0..7, 8 for the cascade output, 9 for the config trigger and 10 for the reset-pin driver. The value/enable stage pairs are: k0 4/3, k1 6/5, k2 2/1, k3 8/7, k4 24/23, k5 10/9, k6 17/16, k7 14/13, k8 12/11, k9 22/21, k10 19/18. The input index j is 0 for clock, 1 for chip enable and 2 for the reset-pin input, at stages 0, 15 and 20.
- R3: The update latches load all 25 shift stages on a clock with `update_dr` high while the ring is selected. Capture, shift, and update while the ring is not selected leave them unchanged.
- R4: With no instruction flag and no in-system programming, and under `ir_sample`, `pad_val` equals `core_val` and `pad_oe` equals `core_oe`.
- R5: Under `ir_extest` or `ir_clamp`, `pad_val[k]` is the update latch at the value stage of output k. `pad_oe[k]` is the latch at its enable stage, where 1 means driving.
- R6: Under `ir_highz`, every bit of `pad_oe` is 0.
- R7: Under `ir_clamp` the ring is not selected and `tdo` shows a one-bit bypass stage. The bypass stage loads 0 on capture and loads `tdi` on shift.
- R8: When `isp_mode` is high, all of `pad_oe` is 0 if `isp_float` is high. If `isp_float` is low, the pads take value and enable from the update latches.
- R9: When `rst_n` is low, all shift stages, update latches and the bypass stage clear to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Test clock |
| rst_n | input | 1 | Synchronous active-low reset |
| capture_dr | input | 1 | Capture strobe from the controller |
| shift_dr | input | 1 | Shift strobe from the controller |
| update_dr | input | 1 | Update strobe from the controller |
| ir_extest | input | 1 | External-test instruction decoded |
| ir_sample | input | 1 | Sample/preload instruction decoded |
| ir_clamp | input | 1 | Clamp instruction decoded |
| ir_highz | input | 1 | All-outputs-off instruction decoded |
| isp_mode | input | 1 | In-system programming active |
| isp_float | input | 1 | Float pads (1) or hold latched levels (0) during programming |
| tdi | input | 1 | Serial scan input |
| tdo | output | 1 | Serial scan output |
| core_val | input | 11 | Core output values, index k as in R2 |
| core_oe | input | 11 | Core output enables, 1 = drive |
| pin_in | input | 3 | Input pin levels, index j as in R2 |
| pad_val | output | 11 | Value sent to each output pad |
| pad_oe | output | 11 | Drive enable sent to each output pad |

## Verification
The capture path is tried with two complementary core/pin patterns. A swapped or mis-assigned stage position shows up as a wrong bit in the shifted-out word. The update path is tried with distinct patterns under external test, with and without an update strobe, and under clamp, where the strobe must not reach the latches. This separates a latch that follows the shift stages from one that loads only when selected. The mode priority is exercised by walking through sample, external test, high-impedance, clamp and both programming variants. The pad outputs are compared after each step against values the bench decodes from its own position table.

// File: rtl/bsr_pkg.sv
// Package: sizes and stage positions of the pin boundary-scan ring.
// Assumes output index k and input index j follow the brief's numbering.
package bsr_pkg;
    localparam int NUM_OUT   = 11;
    localparam int NUM_IN    = 3;
    localparam int CHAIN_LEN = 2 * NUM_OUT + NUM_IN;

    typedef enum logic [1:0] {
        SRC_CORE  = 2'd0,
        SRC_LATCH = 2'd1,
        SRC_FLOAT = 2'd2
    } pad_src_e;

    // Stage holding the value of output k
    function automatic int unsigned val_pos(input int k);
        case (k)
            0: return 4;   1: return 6;   2: return 2;   3: return 8;
            4: return 24;  5: return 10;  6: return 17;  7: return 14;
            8: return 12;  9: return 22;  10: return 19;
            default: return 0;
        endcase
    endfunction

    // Stage holding the drive enable of output k
    function automatic int unsigned en_pos(input int k);
        case (k)
            0: return 3;   1: return 5;   2: return 1;   3: return 7;
            4: return 23;  5: return 9;   6: return 16;  7: return 13;
            8: return 11;  9: return 21;  10: return 18;
            default: return 0;
        endcase
    endfunction

    // Stage observing input j
    function automatic int unsigned in_pos(input int j);
        case (j)
            0: return 0;   1: return 15;  2: return 20;
            default: return 0;
        endcase
    endfunction
endpackage

// File: rtl/bsr_shift_chain.sv
// Shift chain with a separate update latch bank.
// Capture and shift act only when sel is high; the latches load only on
// update while sel is high. Stage LEN-1 is next to TDI, stage 0 drives TDO.
module bsr_shift_chain #(
    parameter int LEN = 25
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           sel,
    input  logic           capture,
    input  logic           shift,
    input  logic           update,
    input  logic           tdi,
    input  logic [LEN-1:0] cap_vec,
    output logic [LEN-1:0] shift_q,
    output logic [LEN-1:0] upd_q
);
    // Capture/shift stages
    always_ff @(posedge clk) begin
        if (!rst_n)
            shift_q <= '0;
        else if (sel && capture)
            shift_q <= cap_vec;
        else if (sel && shift)
            shift_q <= {tdi, shift_q[LEN-1:1]};
    end

    // Update latches, loaded only by the update strobe
    always_ff @(posedge clk) begin
        if (!rst_n)
            upd_q <= '0;
        else if (sel && update)
            upd_q <= shift_q;
    end
endmodule

// File: rtl/bsr_bypass.sv
// One-bit bypass stage used when the ring is not the selected path.
// Assumes the controller only strobes it while it is the selected path.
module bsr_bypass (
    input  logic clk,
    input  logic rst_n,
    input  logic capture,
    input  logic shift,
    input  logic tdi,
    output logic q
);
    // Capture a zero, shift TDI
    always_ff @(posedge clk) begin
        if (!rst_n)
            q <= 1'b0;
        else if (capture)
            q <= 1'b0;
        else if (shift)
            q <= tdi;
    end
endmodule

// File: rtl/bsr_mode_ctl.sv
// Chooses where the pads take their value and enable from.
// Assumes at most one instruction flag is high at a time.
module bsr_mode_ctl
    import bsr_pkg::*;
(
    input  logic     ir_extest,
    input  logic     ir_sample,
    input  logic     ir_clamp,
    input  logic     ir_highz,
    input  logic     isp_mode,
    input  logic     isp_float,
    output pad_src_e pad_src,
    output logic     chain_sel
);
    // Floating has priority, then latched, then core
    always_comb begin
        if (ir_highz || (isp_mode && isp_float))
            pad_src = SRC_FLOAT;
        else if (isp_mode || ir_extest || ir_clamp)
            pad_src = SRC_LATCH;
        else
            pad_src = SRC_CORE;
    end

    // The ring is the scan path for external test and sample only
    always_comb chain_sel = ir_extest || ir_sample;
endmodule

// File: rtl/bsr_out_mux.sv
// Per-pin output multiplexer between the core and the update latches.
// Assumes enable 1 means the pad drives.
module bsr_out_mux
    import bsr_pkg::*;
#(
    parameter int N = 11
) (
    input  pad_src_e     pad_src,
    input  logic [N-1:0] core_val,
    input  logic [N-1:0] core_oe,
    input  logic [N-1:0] lat_val,
    input  logic [N-1:0] lat_oe,
    output logic [N-1:0] pad_val,
    output logic [N-1:0] pad_oe
);
    for (genvar k = 0; k < N; k++) begin : g_pin
        // Select the value and enable of one pad
        always_comb begin
            case (pad_src)
                SRC_LATCH: begin
                    pad_val[k] = lat_val[k];
                    pad_oe[k]  = lat_oe[k];
                end
                SRC_FLOAT: begin
                    pad_val[k] = core_val[k];
                    pad_oe[k]  = 1'b0;
                end
                default: begin
                    pad_val[k] = core_val[k];
                    pad_oe[k]  = core_oe[k];
                end
            endcase
        end
    end
endmodule

// File: rtl/bscan_pin_ring.sv
// Top of the pin boundary-scan ring: builds the capture word from the
// position table, runs the chain and bypass, and drives the pads.
// Assumes all strobes and flags come from one controller on clk.
module bscan_pin_ring
    import bsr_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               capture_dr,
    input  logic               shift_dr,
    input  logic               update_dr,
    input  logic               ir_extest,
    input  logic               ir_sample,
    input  logic               ir_clamp,
    input  logic               ir_highz,
    input  logic               isp_mode,
    input  logic               isp_float,
    input  logic               tdi,
    output logic               tdo,
    input  logic [NUM_OUT-1:0] core_val,
    input  logic [NUM_OUT-1:0] core_oe,
    input  logic [NUM_IN-1:0]  pin_in,
    output logic [NUM_OUT-1:0] pad_val,
    output logic [NUM_OUT-1:0] pad_oe
);
    logic [CHAIN_LEN-1:0] cap_vec;
    logic [CHAIN_LEN-1:0] shift_q;
    logic [CHAIN_LEN-1:0] upd_q;
    logic [NUM_OUT-1:0]   lat_val;
    logic [NUM_OUT-1:0]   lat_oe;
    logic                 byp_q;
    logic                 chain_sel;
    pad_src_e             pad_src;

    // Place core outputs, enables and input levels at their stages
    always_comb begin
        cap_vec = '0;
        for (int k = 0; k < NUM_OUT; k++) begin
            cap_vec[val_pos(k)] = core_val[k];
            cap_vec[en_pos(k)]  = core_oe[k];
        end
        for (int j = 0; j < NUM_IN; j++)
            cap_vec[in_pos(j)] = pin_in[j];
    end

    // Pull each pin's latched value and enable out of the latch bank
    always_comb begin
        for (int k = 0; k < NUM_OUT; k++) begin
            lat_val[k] = upd_q[val_pos(k)];
            lat_oe[k]  = upd_q[en_pos(k)];
        end
    end

    bsr_mode_ctl i_mode (
        .ir_extest (ir_extest),
        .ir_sample (ir_sample),
        .ir_clamp  (ir_clamp),
        .ir_highz  (ir_highz),
        .isp_mode  (isp_mode),
        .isp_float (isp_float),
        .pad_src   (pad_src),
        .chain_sel (chain_sel)
    );

    bsr_shift_chain #(.LEN(CHAIN_LEN)) i_chain (
        .clk     (clk),
        .rst_n   (rst_n),
        .sel     (chain_sel),
        .capture (capture_dr),
        .shift   (shift_dr),
        .update  (update_dr),
        .tdi     (tdi),
        .cap_vec (cap_vec),
        .shift_q (shift_q),
        .upd_q   (upd_q)
    );

    bsr_bypass i_byp (
        .clk     (clk),
        .rst_n   (rst_n),
        .capture (capture_dr && !chain_sel),
        .shift   (shift_dr && !chain_sel),
        .tdi     (tdi),
        .q       (byp_q)
    );

    bsr_out_mux #(.N(NUM_OUT)) i_mux (
        .pad_src  (pad_src),
        .core_val (core_val),
        .core_oe  (core_oe),
        .lat_val  (lat_val),
        .lat_oe   (lat_oe),
        .pad_val  (pad_val),
        .pad_oe   (pad_oe)
    );

    // Scan output: ring stage 0 or bypass
    always_comb tdo = chain_sel ? shift_q[0] : byp_q;
endmodule

// File: rtl/bsr_checker.sv
// Checker for the pin boundary-scan ring, bound to the top module.
module bsr_checker
    import bsr_pkg::*;
(
    input logic                 clk,
    input logic                 rst_n,
    input logic                 update_dr,
    input logic                 shift_dr,
    input logic                 ir_extest,
    input logic                 ir_sample,
    input logic                 ir_clamp,
    input logic                 ir_highz,
    input logic                 isp_mode,
    input logic                 isp_float,
    input logic                 tdi,
    input logic                 tdo,
    input logic [NUM_OUT-1:0]   core_val,
    input logic [NUM_OUT-1:0]   core_oe,
    input logic [NUM_OUT-1:0]   pad_val,
    input logic [NUM_OUT-1:0]   pad_oe,
    input logic [CHAIN_LEN-1:0] upd_q
);
    assert_highz_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ir_highz |-> pad_oe == '0);

    assert_isp_float_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (isp_mode && isp_float) |-> pad_oe == '0);

    assert_latch_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !update_dr |=> $stable(upd_q));

    assert_pass_core_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!ir_extest && !ir_clamp && !ir_highz && !isp_mode)
            |-> (pad_val == core_val && pad_oe == core_oe));

    assert_bypass_shift_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ir_clamp && !ir_extest && !ir_sample && shift_dr) |=> tdo == $past(tdi));
endmodule

bind bscan_pin_ring bsr_checker i_bsr_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .update_dr (update_dr),
    .shift_dr  (shift_dr),
    .ir_extest (ir_extest),
    .ir_sample (ir_sample),
    .ir_clamp  (ir_clamp),
    .ir_highz  (ir_highz),
    .isp_mode  (isp_mode),
    .isp_float (isp_float),
    .tdi       (tdi),
    .tdo       (tdo),
    .core_val  (core_val),
    .core_oe   (core_oe),
    .pad_val   (pad_val),
    .pad_oe    (pad_oe),
    .upd_q     (upd_q)
);

// File: tb/test_bscan_pin_ring.sv
// Directed bench for the pin boundary-scan ring.
module test_bscan_pin_ring;
    logic        clk = 0;
    logic        rst_n = 0;
    logic        capture_dr = 0, shift_dr = 0, update_dr = 0;
    logic        ir_extest = 0, ir_sample = 0, ir_clamp = 0, ir_highz = 0;
    logic        isp_mode = 0, isp_float = 0;
    logic        tdi = 0;
    logic        tdo;
    logic [10:0] core_val = '0, core_oe = '0;
    logic [2:0]  pin_in = '0;
    logic [10:0] pad_val, pad_oe;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    localparam int VPOS [11] = '{4, 6, 2, 8, 24, 10, 17, 14, 12, 22, 19};
    localparam int EPOS [11] = '{3, 5, 1, 7, 23, 9, 16, 13, 11, 21, 18};
    localparam int IPOS [3]  = '{0, 15, 20};

    logic [24:0] lat;   // bench model of the update latches

    bscan_pin_ring i_bscan_pin_ring (.*);

    always #4 clk = ~clk;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [24:0] exp_cap(input logic [10:0] v, input logic [10:0] e,
                                            input logic [2:0] p);
        logic [24:0] r = '0;
        for (int k = 0; k < 11; k++) begin
            r[VPOS[k]] = v[k];
            r[EPOS[k]] = e[k];
        end
        for (int j = 0; j < 3; j++) r[IPOS[j]] = p[j];
        return r;
    endfunction

    function automatic logic [21:0] dec(input logic [24:0] l);
        logic [10:0] v, e;
        for (int k = 0; k < 11; k++) begin
            v[k] = l[VPOS[k]];
            e[k] = l[EPOS[k]];
        end
        return {v, e};
    endfunction

    // Capture, shift 25 bits (first bit first), optional update
    task automatic scan(input logic [24:0] din, input bit do_upd, output logic [24:0] dout);
        @(negedge clk) capture_dr = 1;
        @(negedge clk) begin capture_dr = 0; shift_dr = 1; end
        for (int i = 0; i < 25; i++) begin
            dout[i] = tdo;
            tdi = din[i];
            @(negedge clk);
        end
        shift_dr = 0;
        if (do_upd) begin
            update_dr = 1;
            @(negedge clk) update_dr = 0;
        end
        @(negedge clk);
    endtask

    task automatic t_reset();
        core_val = 11'h3A5; core_oe = 11'h1C3;
        rst_n = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        check("R4 reset pass val", pad_val, core_val);
        check("R4 reset pass oe", pad_oe, core_oe);
        ir_sample = 1;
        #1 check("R9 tdo after reset", tdo, 0);
        ir_sample = 0;
    endtask

    task automatic t_sample();
        logic [24:0] d;
        ir_sample = 1;
        core_val = 11'h5A3; core_oe = 11'h2CF; pin_in = 3'b101;
        scan(25'h0ABCDEF, 1, d);
        lat = 25'h0ABCDEF;
        check("R2 capture pattern A", d, exp_cap(11'h5A3, 11'h2CF, 3'b101));
        check("R4 sample pass val", pad_val, core_val);
        check("R4 sample pass oe", pad_oe, core_oe);
        core_val = ~11'h5A3; core_oe = ~11'h2CF; pin_in = 3'b010;
        scan(25'h1234567, 1, d);
        lat = 25'h1234567;
        check("R2 capture pattern B", d, exp_cap(~11'h5A3, ~11'h2CF, 3'b010));
        ir_sample = 0;
    endtask

    task automatic t_extest();
        logic [24:0] d;
        ir_extest = 1;
        #1 check("R5 extest pads from preload", {pad_val, pad_oe}, dec(lat));
        core_val = 11'h0F0; core_oe = 11'h70F; pin_in = 3'b110;
        scan(25'h1FFFFFF, 0, d);
        check("R1 extest shift-out capture", d, exp_cap(11'h0F0, 11'h70F, 3'b110));
        check("R3 no update keeps pads", {pad_val, pad_oe}, dec(lat));
        scan(25'h0C3A5F1, 1, d);
        lat = 25'h0C3A5F1;
        check("R5 extest pads after update", {pad_val, pad_oe}, dec(lat));
        ir_extest = 0;
    endtask

    task automatic t_highz();
        ir_highz = 1; core_oe = 11'h7FF;
        #1 check("R6 highz all off", pad_oe, 0);
        ir_highz = 0;
    endtask

    task automatic t_clamp();
        logic [24:0] d;
        ir_clamp = 1;
        #1 check("R5 clamp pads from latches", {pad_val, pad_oe}, dec(lat));
        scan(25'h15A5A5A, 1, d);
        check("R7 bypass path", d, {25'h15A5A5A, 1'b0} & 25'h1FFFFFF);
        check("R3 clamp update ignored", {pad_val, pad_oe}, dec(lat));
        ir_clamp = 0;
    endtask

    task automatic t_isp();
        isp_mode = 1; isp_float = 1; core_oe = 11'h7FF;
        #1 check("R8 isp float", pad_oe, 0);
        isp_float = 0;
        #1 check("R8 isp hold latched", {pad_val, pad_oe}, dec(lat));
        isp_mode = 0;
        #1 check("R4 back to core", {pad_val, pad_oe}, {core_val, core_oe});
    endtask

    task automatic t_rst_latch();
        @(negedge clk) rst_n = 0;
        @(negedge clk) rst_n = 1;
        ir_extest = 1;
        #1 check("R9 latches cleared", {pad_val, pad_oe}, 0);
        ir_extest = 0;
    endtask

    initial begin
        t_reset();
        t_sample();
        t_extest();
        t_highz();
        t_clamp();
        t_isp();
        t_rst_latch();
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule